// File: doc/BRIEF.md
# DRAM Bring-Up and Parallel-Test Sequencer

This block sits on the controller side of an asynchronous fast-page/EDO DRAM and owns the memory's first moments after reset. It keeps every strobe inactive through a power-up wait, then issues a burst of refresh cycles that condition the array. After that it reports itself ready.

On request it runs a compressed self-test session. It latches the memory into its parallel-test mode with a special refresh ordering and issues a fixed number of test reads. Each read returns one bit that says whether four internal cells agreed. The session then leaves test mode with a plain refresh and reports a sticky pass/fail verdict together with a one-cycle done pulse.

Every interval is a whole number of clock cycles set at elaboration. The test-read access time is stretched by a fixed margin, which is rounded up to whole cycles from the clock period.

Top module: `dram_bringup_seq`

## Requirements
- R1: After rst_ni is released, ras_no, cas_no and we_no stay high for exactly STARTUP_CYC rising clock edges; the first strobe goes low after edge number STARTUP_CYC.
- R2: Before ready_o is first high or any test session starts, exactly INIT_CYCLES refresh cycles are issued, each with cas_no falling before ras_no and we_no high; ready_o stays low until they are done.
- R3: A test session opens with a test-entry cycle: cas_no falls CSR_CYC cycles before ras_no, and we_no is low when ras_no falls.
- R4: Inside test mode the sequencer issues NUM_READS reads. In each read ras_no falls while cas_no is high, then cas_no falls while ras_no is low, and the column address bits [1:0] are 0.
- R5: A test read samples dq_i at the end of ACC_CYC plus ceil(TEST_MARGIN_PS/CLK_PS) cycles of cas_no low. dq_i = 1 counts as a pass and dq_i = 0 as a fail.
- R6: we_no is high whenever cas_no falls in a read, and stays high for at least RDH_CYC cycles after cas_no rises.
- R7: After the last read, test mode is left with a refresh in which ras_no falls while cas_no is high and we_no is high.
- R8: fail_o is set by any failing test read, is cleared when a new session starts, and is valid when done_o pulses for one cycle after the exit cycle's precharge.
- R9: A test_req_i pulse that arrives while ready_o is low is kept pending and is served without being repeated.
- R10: ready_o is low while a session runs and is high in the same cycle as done_o when no further request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| test_req_i | input | 1 | Request for a parallel-test session (pulse) |
| ready_o | output | 1 | Idle with initialization finished and no request pending |
| done_o | output | 1 | One-cycle pulse at the end of a test session |
| fail_o | output | 1 | Sticky verdict of the last session; 1 means a mismatch was seen |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | Multiplexed row/column address |
| dq_i | input | 1 | Compressed test-read data bit |

## Verification
The memory model in the bench drives the inverse of the expected bit on dq_i until the cycle just before the stretched sample edge. A sequencer that forgets the test margin therefore reads the wrong verdict. A sequencer that issues a test read before the entry ordering, or that leaves test mode with we_no low, shows up as a miscount of entries, reads and exits. A failing session followed by a passing one catches a fail flag that is never cleared. A request pulsed during the power-up wait catches a sequencer that drops requests made before it is ready. The bench also counts the initialization refreshes and times the first strobe, so an off-by-one in either count is caught.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
  typedef enum logic [3:0] {
    ST_PWR, ST_CBR_CAS, ST_CBR_RAS, ST_ROR_RAS, ST_RD_ROW,
    ST_RD_CAS, ST_RD_HOLD, ST_PRE, ST_IDLE
  } seq_state_e;

  typedef enum logic [1:0] {
    PH_INIT, PH_ENTER, PH_READ, PH_EXIT
  } seq_phase_e;
endpackage

// File: rtl/dram_seq_timer.sv
module dram_seq_timer #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 100
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= CNT_W'(RST_LEN - 1);
    else if (load_i)            cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/dram_seq_verdict.sv
module dram_seq_verdict (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic sample_i,
  input  logic bit_i,
  output logic fail_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 fail_o <= 1'b0;
    else if (clr_i)              fail_o <= 1'b0;
    else if (sample_i && !bit_i) fail_o <= 1'b1;
  end
endmodule

// File: rtl/dram_seq_req.sv
module dram_seq_req (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic take_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (take_i) pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
  end
endmodule

// File: rtl/dram_bringup_seq.sv
module dram_bringup_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W         = 11,
  parameter int STARTUP_CYC    = 40000,
  parameter int INIT_CYCLES    = 8,
  parameter bit INIT_ROR       = 1'b0,
  parameter int NUM_READS      = 4,
  parameter int CSR_CYC        = 2,
  parameter int RAS_CYC        = 6,
  parameter int RCD_CYC        = 2,
  parameter int ACC_CYC        = 3,
  parameter int RDH_CYC        = 1,
  parameter int PRE_CYC        = 4,
  parameter int CLK_PS         = 5000,
  parameter int TEST_MARGIN_PS = 5000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              test_req_i,
  output logic              ready_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [ADDR_W-1:0] addr_o,
  input  logic              dq_i
);
  localparam int TEST_EXTRA = (TEST_MARGIN_PS + CLK_PS - 1) / CLK_PS;
  localparam int TACC_CYC   = ACC_CYC + TEST_EXTRA;
  localparam int M1         = (RAS_CYC > PRE_CYC) ? RAS_CYC : PRE_CYC;
  localparam int M2         = (TACC_CYC > M1) ? TACC_CYC : M1;
  localparam int M3         = (STARTUP_CYC > M2) ? STARTUP_CYC : M2;
  localparam int CNT_W      = $clog2(M3 + 1);
  localparam int ITEM_MAX   = (INIT_CYCLES > NUM_READS) ? INIT_CYCLES : NUM_READS;
  localparam int ITEM_W     = $clog2(ITEM_MAX + 1);

  seq_state_e state_q, state_d;
  seq_phase_e phase_q, phase_d;
  logic [ITEM_W-1:0] item_q, item_d;
  logic [CNT_W-1:0]  len;
  logic expire, start, sample, tm_set, tm_clr, fin, pend, req;
  logic tmode_q;
  logic ras_d, cas_d, we_d;
  logic [ADDR_W-1:0] addr_d;

  dram_seq_timer #(.CNT_W(CNT_W), .RST_LEN(STARTUP_CYC)) i_timer (
    .clk_i, .rst_ni, .load_i(expire), .len_i(len), .expire_o(expire)
  );

  dram_seq_req i_req (
    .clk_i, .rst_ni, .set_i(test_req_i), .take_i(start), .pend_o(pend)
  );

  dram_seq_verdict i_verdict (
    .clk_i, .rst_ni, .clr_i(start), .sample_i(sample), .bit_i(dq_i), .fail_o(fail_o)
  );

  assign req = pend | test_req_i;

  always_comb begin
    state_d = state_q;
    phase_d = phase_q;
    item_d  = item_q;
    start   = 1'b0;
    sample  = 1'b0;
    tm_set  = 1'b0;
    tm_clr  = 1'b0;
    fin     = 1'b0;
    if (expire) begin
      unique case (state_q)
        ST_PWR: begin
          phase_d = PH_INIT;
          item_d  = '0;
          state_d = INIT_ROR ? ST_ROR_RAS : ST_CBR_CAS;
        end
        ST_CBR_CAS: state_d = ST_CBR_RAS;
        ST_CBR_RAS: begin
          state_d = ST_PRE;
          tm_set  = (phase_q == PH_ENTER);
        end
        ST_ROR_RAS: begin
          state_d = ST_PRE;
          tm_clr  = (phase_q == PH_EXIT);
        end
        ST_RD_ROW:  state_d = ST_RD_CAS;
        ST_RD_CAS: begin
          state_d = ST_RD_HOLD;
          sample  = 1'b1;
        end
        ST_RD_HOLD: state_d = ST_PRE;
        ST_PRE: begin
          unique case (phase_q)
            PH_INIT: begin
              if (item_q == ITEM_W'(INIT_CYCLES - 1)) begin
                state_d = ST_IDLE;
                item_d  = '0;
              end else begin
                item_d  = item_q + ITEM_W'(1);
                state_d = INIT_ROR ? ST_ROR_RAS : ST_CBR_CAS;
              end
            end
            PH_ENTER: begin
              phase_d = PH_READ;
              item_d  = '0;
              state_d = ST_RD_ROW;
            end
            PH_READ: begin
              if (item_q == ITEM_W'(NUM_READS - 1)) begin
                phase_d = PH_EXIT;
                state_d = ST_ROR_RAS;
              end else begin
                item_d  = item_q + ITEM_W'(1);
                state_d = ST_RD_ROW;
              end
            end
            default: begin
              state_d = ST_IDLE;
              fin     = 1'b1;
            end
          endcase
        end
        ST_IDLE: begin
          if (req) begin
            start   = 1'b1;
            phase_d = PH_ENTER;
            state_d = ST_CBR_CAS;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_d)
      ST_PWR:     len = CNT_W'(STARTUP_CYC);
      ST_CBR_CAS: len = CNT_W'(CSR_CYC);
      ST_CBR_RAS,
      ST_ROR_RAS: len = CNT_W'(RAS_CYC);
      ST_RD_ROW:  len = CNT_W'(RCD_CYC);
      ST_RD_CAS:  len = (tmode_q || tm_set) ? CNT_W'(TACC_CYC) : CNT_W'(ACC_CYC);
      ST_RD_HOLD: len = CNT_W'(RDH_CYC);
      ST_PRE:     len = CNT_W'(PRE_CYC);
      default:    len = CNT_W'(1);
    endcase
  end

  // Strobes are registered from the next state so they change with the state
  always_comb begin
    ras_d  = !(state_d inside {ST_CBR_RAS, ST_ROR_RAS, ST_RD_ROW, ST_RD_CAS});
    cas_d  = !(state_d inside {ST_CBR_CAS, ST_CBR_RAS, ST_RD_CAS});
    we_d   = !((phase_d == PH_ENTER) && (state_d inside {ST_CBR_CAS, ST_CBR_RAS}));
    addr_d = '0;
    if (state_d inside {ST_ROR_RAS, ST_RD_ROW}) addr_d = ADDR_W'(item_d);
    else if (state_d == ST_RD_CAS)              addr_d = ADDR_W'({item_d, 2'b00});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_PWR;
      phase_q <= PH_INIT;
      item_q  <= '0;
      tmode_q <= 1'b0;
      done_o  <= 1'b0;
      ras_no  <= 1'b1;
      cas_no  <= 1'b1;
      we_no   <= 1'b1;
      addr_o  <= '0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      item_q  <= item_d;
      if (tm_set)      tmode_q <= 1'b1;
      else if (tm_clr) tmode_q <= 1'b0;
      done_o  <= fin;
      ras_no  <= ras_d;
      cas_no  <= cas_d;
      we_no   <= we_d;
      addr_o  <= addr_d;
    end
  end

  assign ready_o = (state_q == ST_IDLE) && !pend;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
  parameter int STARTUP_CYC = 40000,
  parameter int INIT_CYCLES = 8,
  parameter int RDH_CYC     = 1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ras_no,
  input logic cas_no,
  input logic we_no,
  input logic ready_o,
  input logic done_o
);
  localparam int UP_W  = $clog2(STARTUP_CYC + 1);
  localparam int REF_W = $clog2(INIT_CYCLES + 1);
  localparam int HLD_W = $clog2(RDH_CYC + 1);

  logic [UP_W-1:0]  up_q;
  logic [REF_W-1:0] ref_q;
  logic [HLD_W-1:0] hld_q;
  logic prv_ras, prv_cas;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q    <= '0;
      ref_q   <= '0;
      hld_q   <= '0;
      prv_ras <= 1'b1;
      prv_cas <= 1'b1;
    end else begin
      prv_ras <= ras_no;
      prv_cas <= cas_no;
      if (up_q != UP_W'(STARTUP_CYC)) up_q <= up_q + UP_W'(1);
      if (prv_ras && !ras_no && !cas_no && we_no && ref_q != REF_W'(INIT_CYCLES))
        ref_q <= ref_q + REF_W'(1);
      if (!prv_cas && cas_no)  hld_q <= HLD_W'(RDH_CYC);
      else if (hld_q != '0)    hld_q <= hld_q - HLD_W'(1);
    end
  end

  AST_QUIET_STARTUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q < UP_W'(STARTUP_CYC)) |-> (ras_no && cas_no && we_no)); // R1

  AST_NO_EARLY_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ref_q == REF_W'(INIT_CYCLES))); // R2

  AST_ENTRY_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && !we_no) |-> (!cas_no && !prv_cas)); // R3

  AST_WE_HIGH_AT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_no) && !ras_no) |-> we_no); // R6

  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hld_q != '0) |-> we_no); // R6

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8

  AST_READY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (ras_no && cas_no)); // R10
endmodule

bind dram_bringup_seq dram_seq_chk #(
  .STARTUP_CYC(STARTUP_CYC), .INIT_CYCLES(INIT_CYCLES), .RDH_CYC(RDH_CYC)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ras_no(ras_no), .cas_no(cas_no),
  .we_no(we_no), .ready_o(ready_o), .done_o(done_o)
);

// File: tb/test_dram_bringup_seq.sv
module test_dram_bringup_seq;
  localparam int ADDR_W  = 11;
  localparam int STARTUP = 50;
  localparam int NINIT   = 8;
  localparam int NREAD   = 4;
  localparam int ACC     = 3;
  localparam int D_TEST  = ACC + 1; // 5 ns margin at 5 ns period
  localparam int NVEC    = 6;
  // {expected fail, dq per read [3:0]}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b0_1111, 5'b1_1110, 5'b1_0111, 5'b0_1111, 5'b1_0000, 5'b1_1011
  };

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, dq;
  logic ready, done, fail, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] addr;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  dram_bringup_seq #(.ADDR_W(ADDR_W), .STARTUP_CYC(STARTUP), .INIT_CYCLES(NINIT),
    .NUM_READS(NREAD), .ACC_CYC(ACC)) i_dram_bringup_seq (
    .clk_i(clk), .rst_ni(rst_n), .test_req_i(req), .ready_o(ready), .done_o(done),
    .fail_o(fail), .ras_no(ras_n), .cas_no(cas_n), .we_no(we_n), .addr_o(addr), .dq_i(dq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // memory model and strobe monitor
  logic [3:0] pat = 4'hF;
  int rel_cyc = 0, first_strobe = -1, cbr_cnt = 0, init_cbr = -1;
  int entry_cnt = 0, exit_cnt = 0, read_cnt = 0, ridx = 0, k = 0;
  bit tmode = 0, ror_open = 0, in_read = 0, early_ready = 0;
  logic prv_ras = 1'b1, prv_cas = 1'b1;

  always @(posedge clk) if (rst_n) rel_cyc++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (first_strobe < 0 && (!ras_n || !cas_n || !we_n)) first_strobe = rel_cyc;
      if (init_cbr < 0 && ready) early_ready = 1;
      if (prv_ras && !ras_n) begin
        if (!cas_n) begin
          if (!we_n) begin
            entry_cnt++; tmode = 1; ridx = 0;
            if (init_cbr < 0) init_cbr = cbr_cnt;
            chk(!ready, "R10 ready low in session", ready, 0);
          end else cbr_cnt++;
        end else ror_open = 1;
      end
      if (prv_cas && !cas_n && !ras_n) begin
        ror_open = 0; in_read = 1; k = 0;
        chk(we_n == 1'b1, "R6 we high at read", we_n, 1);
        chk(tmode, "R4 read inside test mode", tmode, 1);
        chk(addr[1:0] == 2'b00, "R4 column low bits", addr[1:0], 0);
      end else if (in_read && !cas_n) k++;
      if (in_read && cas_n) begin
        in_read = 0; read_cnt++; ridx++;
        chk(we_n == 1'b1, "R6 we high after read", we_n, 1);
      end
      if (!prv_ras && ras_n && ror_open) begin
        ror_open = 0;
        if (tmode) begin
          exit_cnt++; tmode = 0;
          chk(we_n == 1'b1, "R7 exit with we high", we_n, 1);
        end
      end
      prv_ras = ras_n;
      prv_cas = cas_n;
    end
    dq = (in_read && ridx < 4) ? ((k >= D_TEST - 1) ? pat[ridx] : ~pat[ridx]) : 1'b0;
  end

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
  endtask

  task automatic pulse_req();
    @(negedge clk) req = 1'b1;
    @(negedge clk) req = 1'b0;
  endtask

  task automatic check_session(input int n, input logic [4:0] v, input string tag);
    bit seen;
    wait_done(seen);
    chk(seen, {tag, " R8 done pulse"}, seen, 1);
    chk(fail == v[4], {tag, " R5 R8 verdict"}, fail, v[4]);
    chk(entry_cnt == n, {tag, " R3 entries"}, entry_cnt, n);
    chk(exit_cnt == n, {tag, " R7 exits"}, exit_cnt, n);
    chk(read_cnt == n * NREAD, {tag, " R4 reads"}, read_cnt, n * NREAD);
    chk(ready == 1'b1, {tag, " R10 ready with done"}, ready, 1);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
    chk(!ready && !done && !fail, "R10 outputs idle in reset", {ready, done, fail}, 0);
    rst_n = 1'b1;
    // early request during the power-up wait
    pat = VEC[0][3:0];
    repeat (5) @(negedge clk);
    pulse_req();
    check_session(1, VEC[0], "early");
    chk(first_strobe == STARTUP, "R1 first strobe edge", first_strobe, STARTUP);
    chk(init_cbr == NINIT, "R2 init refresh count", init_cbr, NINIT);
    chk(!early_ready, "R2 R9 no ready before session", early_ready, 0);
    for (int i = 1; i < NVEC; i++) begin
      pat = VEC[i][3:0];
      pulse_req();
      check_session(i + 1, VEC[i], $sformatf("vec%0d", i));
    end
    // sticky flag cleared by a new passing session after a fail
    pat = 4'hF;
    pulse_req();
    check_session(NVEC + 1, 5'b0_1111, "clear");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule